// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers peripheral interrupt requests into a pending register, one bit per source. It picks the highest-ranked source that is both pending and enabled by the mask register. When the host runs an acknowledge handshake, the block returns that source as an 8-bit vector. The vector holds a 3-bit base, written by the host, above the 5-bit source number. A single interrupt line tells the host that at least one enabled source is waiting.

The ranking comes from a fixed table, and the table has two layouts. In the grouped layout the four serial-channel sources, 31 down to 28, fill the top four slots. In the spread layout those four sit in slots 0, 8, 16 and 24, and the other sources keep their descending order around them. A promote field names one source that outranks the whole table. This field may be rewritten at any time.

Pending bits clear in two ways:
- The acknowledge cycle clears the bit of the source it vectors.
- The host writes a one to clear a bit.

A source flagged as having its own event register is never cleared by an acknowledge. Its pending bit follows its request level.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the following hold:
  - pending (address 1) and mask (address 2) read 0.
  - config (address 0) reads 32'h0000_001F.
  - intOut is 0.
  - Config layout: promote field in bits [4:0], vector base in bits [7:5], spread bit in bit 8.
- R2: A request input high at a clock edge sets the pending bit at the same bit position after that edge. Bit positions do not depend on the layout or the promote field. Source 0 does not exist: its pending bit always reads 0.
- R3: A host write to address 1 clears each pending bit written as 1. Bits written as 0 keep their value. The host can never set a pending bit.
- R4: intOut is 1 exactly when some pending bit has its mask bit at 1. A mask bit of 1 enables the source.
- R5: ackReq high at an edge gives ackVld high for the next cycle. ackVec is {base, winning source number}. The winner's pending bit is cleared at that same edge.
- R6: A source with hasEvt set is not cleared by an acknowledge. Its pending bit follows its request level, so it drops when the request drops.
- R7: With spread = 0, rank is descending source number: 31 is highest and 1 is lowest.
- R8: With spread = 1:
  - Sources 31, 30, 29 and 28 occupy slots 0, 8, 16 and 24.
  - Sources 27 down to 1 fill the remaining slots in descending order.
  - Slot 0 is the highest rank.
- R9: If the promote field names a pending, enabled source, that source wins over every other. The value 31 leaves the table order unchanged.
- R10: An acknowledge while no enabled source is pending returns source code 0 ({base, 5'b00000}). It leaves the pending register unchanged.
- R11: Until config has been written once after reset, every acknowledge returns 8'h0F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 config, 1 pending, 2 mask |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr, combinational |
| req | input | 32 | Per-source request levels |
| hasEvt | input | 32 | Per-source flag: source has its own event register |
| ackReq | input | 1 | Acknowledge request |
| ackVld | output | 1 | Acknowledge response valid |
| ackVec | output | 8 | Returned interrupt vector |
| intOut | output | 1 | Some enabled source is pending |

## Verification
The bench builds the block with the package defaults:
- a 5-bit source number, giving 31 real sources;
- four serial-channel sources spread every eighth slot.

With these values both table layouts can be reached, including the slots 1, 9, 10 and 16 where a serial source and an ordinary source trade rank between layouts. The promote field, the event-register level behaviour, the error vector and the uninitialized vector 8'h0F are each reached by directed acknowledges with known pending contents.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int SRC_W       = 5;
  localparam int NUM_SRC     = 1 << SRC_W;
  localparam int BASE_W      = 3;
  localparam int VEC_W       = SRC_W + BASE_W;
  localparam int NUM_SERIAL  = 4;
  localparam int SPREAD_STEP = 8;
  localparam int CFG_W       = SRC_W + BASE_W + 1;
  localparam logic [VEC_W-1:0] UNINIT_VEC = 8'h0F;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_PEND = 2'd1;
  localparam logic [1:0] ADDR_MASK = 2'd2;

  typedef struct packed {
    logic cfgWr;
    logic pendClr;
    logic maskWr;
    logic ackTake;
  } strobe_t;

  // Source held in a table slot; slot 0 ranks highest.
  function automatic logic [SRC_W-1:0] slotSrc(int slot, logic spread);
    int nSer;
    int k;
    if (!spread) return SRC_W'(NUM_SRC - 1 - slot);
    if ((slot % SPREAD_STEP) == 0 && (slot / SPREAD_STEP) < NUM_SERIAL)
      return SRC_W'(NUM_SRC - 1 - slot / SPREAD_STEP);
    nSer = slot / SPREAD_STEP + 1;
    if (nSer > NUM_SERIAL) nSer = NUM_SERIAL;
    k = slot - nSer;
    return SRC_W'(NUM_SRC - 1 - NUM_SERIAL - k);
  endfunction
endpackage

// File: rtl/ivc_ctrl.sv
module ivc_ctrl
  import ivc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] addr,
  input  logic       ackReq,
  output strobe_t    strobe,
  output logic       ackVld
);
  always_comb begin
    strobe.cfgWr   = wrEn && (addr == ADDR_CFG);
    strobe.pendClr = wrEn && (addr == ADDR_PEND);
    strobe.maskWr  = wrEn && (addr == ADDR_MASK);
    strobe.ackTake = ackReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackVld <= 1'b0;
    else       ackVld <= ackReq;
  end
endmodule

// File: rtl/ivc_datapath.sv
module ivc_datapath
  import ivc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [1:0]         addr,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] hasEvt,
  output logic [NUM_SRC-1:0] rdData,
  output logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] mask,
  output logic               baseWritten,
  output logic [VEC_W-1:0]   ackVec,
  output logic               intOut
);
  logic [SRC_W-1:0]   topSrc;
  logic [BASE_W-1:0]  vecBase;
  logic               spread;
  logic [NUM_SRC-1:0] active;
  logic [NUM_SRC-1:0] pendNext;
  logic [SRC_W-1:0]   win;
  logic               found;

  assign active = pend & mask;
  assign intOut = |active;

  always_comb begin
    win   = '0;
    found = 1'b0;
    for (int s = NUM_SRC - 2; s >= 0; s--) begin
      if (active[slotSrc(s, spread)]) begin
        win   = slotSrc(s, spread);
        found = 1'b1;
      end
    end
    if (topSrc != '0 && active[topSrc]) begin
      win   = topSrc;
      found = 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      if (hasEvt[i])
        pendNext[i] = req[i];
      else
        pendNext[i] = req[i] |
          (pend[i] & ~(strobe.pendClr & wrData[i])
                   & ~(strobe.ackTake & found & (win == SRC_W'(i))));
    end
    pendNext[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend        <= '0;
      mask        <= '0;
      topSrc      <= '1;
      vecBase     <= '0;
      spread      <= 1'b0;
      baseWritten <= 1'b0;
      ackVec      <= '0;
    end else begin
      pend <= pendNext;
      if (strobe.maskWr) mask <= wrData;
      if (strobe.cfgWr) begin
        topSrc      <= wrData[SRC_W-1:0];
        vecBase     <= wrData[SRC_W+BASE_W-1:SRC_W];
        spread      <= wrData[CFG_W-1];
        baseWritten <= 1'b1;
      end
      if (strobe.ackTake)
        ackVec <= baseWritten ? {vecBase, (found ? win : SRC_W'(0))} : UNINIT_VEC;
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_CFG:  rdData = NUM_SRC'({spread, vecBase, topSrc});
      ADDR_PEND: rdData = pend;
      ADDR_MASK: rdData = mask;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         addr,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] rdData,
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] hasEvt,
  input  logic               ackReq,
  output logic               ackVld,
  output logic [VEC_W-1:0]   ackVec,
  output logic               intOut
);
  strobe_t            strobe;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] mask;
  logic               baseWritten;

  ivc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .ackReq(ackReq), .strobe(strobe), .ackVld(ackVld)
  );

  ivc_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr),
    .wrData(wrData), .req(req), .hasEvt(hasEvt), .rdData(rdData),
    .pend(pend), .mask(mask), .baseWritten(baseWritten),
    .ackVec(ackVec), .intOut(intOut)
  );
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
  import ivc_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               ackReq,
  input logic               ackVld,
  input logic [VEC_W-1:0]   ackVec,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] mask,
  input logic [NUM_SRC-1:0] req,
  input logic               baseWritten
);
  assert_ack_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |=> ackVld);
  assert_ack_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ackReq |=> !ackVld);
  assert_vec_pending_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ackVld && baseWritten && ackVec[SRC_W-1:0] != '0) |->
      ((($past(pend & mask) >> ackVec[SRC_W-1:0]) & NUM_SRC'(1)) != '0));
  assert_error_vec_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ackVld && baseWritten && ackVec[SRC_W-1:0] == '0) |->
      ($past(pend & mask) == '0));
  assert_uninit_vec_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ackVld && !baseWritten) |-> (ackVec == UNINIT_VEC));
  assert_no_host_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(req)) == '0));
  assert_no_src0_R2: assert property (@(posedge clk) disable iff (!rstN)
    !pend[0]);
endmodule

bind irq_vector_ctrl ivc_checker chk_i (
  .clk(clk), .rstN(rstN), .ackReq(ackReq), .ackVld(ackVld),
  .ackVec(ackVec), .pend(pend), .mask(mask), .req(req),
  .baseWritten(baseWritten)
);

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] req = '0;
  logic [31:0] hasEvt = '0;
  logic        ackReq = 1'b0;
  logic        ackVld;
  logic [7:0]  ackVec;
  logic        intOut;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .req(req), .hasEvt(hasEvt), .ackReq(ackReq),
    .ackVld(ackVld), .ackVec(ackVec), .intOut(intOut)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrReg(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdReg(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdData;
  endtask

  task automatic pulseReq(logic [31:0] bits);
    @(negedge clk); req = bits;
    @(negedge clk); req = '0;
  endtask

  task automatic doAck(string tag, logic [7:0] expVec);
    @(negedge clk); ackReq = 1'b1;
    @(negedge clk); ackReq = 1'b0;
    check({tag, " ackVld"}, {31'd0, ackVld}, 32'd1);
    check({tag, " ackVec"}, {24'd0, ackVec}, {24'd0, expVec});
  endtask

  task automatic checkPend(string tag, logic [31:0] exp);
    logic [31:0] d;
    rdReg(2'd1, d);
    check(tag, d, exp);
  endtask

  task automatic testReset();
    logic [31:0] d;
    rdReg(2'd1, d); check("R1 pending", d, 32'h0);
    rdReg(2'd2, d); check("R1 mask", d, 32'h0);
    rdReg(2'd0, d); check("R1 config", d, 32'h1F);
    check("R1 intOut", {31'd0, intOut}, 32'd0);
  endtask

  task automatic testUninit();
    wrReg(2'd2, 32'hFFFF_FFFF);
    pulseReq(32'h1000);
    check("R4 intOut set", {31'd0, intOut}, 32'd1);
    doAck("R11 uninit", 8'h0F);
    checkPend("R5 cleared after uninit ack", 32'h0);
  endtask

  task automatic testGrouped();
    wrReg(2'd0, 32'hBF);
    pulseReq(32'h0002_0008);
    checkPend("R2 positions", 32'h0002_0008);
    doAck("R7 grouped first", 8'hB1);
    checkPend("R5 winner cleared", 32'h8);
    doAck("R7 grouped second", 8'hA3);
    checkPend("R5 all cleared", 32'h0);
  endtask

  task automatic testW1c();
    pulseReq(32'h150);
    wrReg(2'd1, 32'h40);
    checkPend("R3 one clears", 32'h110);
    wrReg(2'd1, 32'h0);
    checkPend("R3 zero keeps", 32'h110);
    wrReg(2'd1, 32'hFFFF_FFFF);
    checkPend("R3 clear all no set", 32'h0);
  endtask

  task automatic testError();
    wrReg(2'd2, 32'h0);
    pulseReq(32'h80);
    check("R4 masked intOut", {31'd0, intOut}, 32'd0);
    doAck("R10 error vector", 8'hA0);
    checkPend("R10 pending unchanged", 32'h80);
    wrReg(2'd2, 32'hFFFF_FFFF);
    check("R4 unmasked intOut", {31'd0, intOut}, 32'd1);
    doAck("R5 after unmask", 8'hA7);
  endtask

  task automatic testSpread();
    pulseReq(32'h1800_0000);
    doAck("R7 grouped 28 over 27", 8'hBC);
    wrReg(2'd1, 32'hFFFF_FFFF);
    wrReg(2'd0, 32'h1BF);
    pulseReq(32'h1800_0000);
    checkPend("R2 positions fixed in spread", 32'h1800_0000);
    doAck("R8 spread 27 over 28", 8'hBB);
    doAck("R8 spread then 28", 8'hBC);
    pulseReq(32'h2008_0000);
    doAck("R8 spread 19 over 29", 8'hB3);
    doAck("R8 spread then 29", 8'hBD);
    pulseReq(32'h4010_0000);
    doAck("R8 spread 30 over 20", 8'hBE);
    doAck("R8 spread then 20", 8'hB4);
  endtask

  task automatic testPromote();
    wrReg(2'd0, 32'hA5);
    pulseReq(32'h8000_0020);
    doAck("R9 promoted 5", 8'hA5);
    doAck("R9 then 31", 8'hBF);
  endtask

  task automatic testEvent();
    hasEvt = 32'h200;
    @(negedge clk); req = 32'h200;
    @(negedge clk);
    checkPend("R6 level sets", 32'h200);
    doAck("R6 event ack", 8'hA9);
    checkPend("R6 not cleared by ack", 32'h200);
    @(negedge clk); req = '0;
    @(negedge clk);
    checkPend("R6 follows level", 32'h0);
    hasEvt = '0;
  endtask

  task automatic testSrc0();
    pulseReq(32'h1);
    checkPend("R2 source 0 absent", 32'h0);
    check("R2 source 0 no intOut", {31'd0, intOut}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testUninit();
    testGrouped();
    testW1c();
    testError();
    testSpread();
    testPromote();
    testEvent();
    testSrc0();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule